// File: doc/BRIEF.md
# DSSS PSK Packet Modulator Sequencer

This block is the symbol and chip engine of a direct-sequence spread-spectrum transmitter. A single `start` pulse launches a packet made of three sections sent back to back: a synchronisation preamble that the block generates itself, then a header, then a payload. The header and payload bits come from a host one at a time over a request/data handshake. Every symbol is scrambled, differentially phase-encoded, and spread into 11 chips. One chip leaves the block on each clock as a pair of I/Q sign bits.

Each section has its own modulation mode. The preamble is always sent in differential BPSK. The header is sent in DBPSK or DQPSK, as configured. The payload is sent in DBPSK, DQPSK, or one of two codes reserved for CCK rates. The block changes mode at the section boundaries without help from outside. The accumulated carrier phase carries across every boundary, so the differential reference is never lost. The block latches the configuration at `start`, so the host may change its inputs freely while a packet is being sent.

Top module: `dsss_tx_seq`

## Requirements
- R1: After a synchronous reset, `chip_valid`, `chip_i_neg`, `chip_q_neg`, `bit_req` and `done` are all 0.
- R2: When the block is idle, a `start` pulse latches `hdr_mode`, `data_mode`, `pre_len`, `hdr_len`, `dat_len` and `seed`. While a packet is in progress, changes to these inputs and further `start` pulses have no effect on the output.
- R3: The preamble has `pre_len` symbols (at least 1). Each symbol carries one internally supplied bit of value 1 in DBPSK, and the preamble issues no host bit requests.
- R4: The header has `hdr_len` symbols (at least 1). `hdr_mode`=0 selects DBPSK with 1 host bit per symbol, and `hdr_mode`=1 selects DQPSK with 2 host bits per symbol.
- R5: The payload has `dat_len` symbols (at least 1). The `data_mode` codes are: 00 selects DBPSK with 1 bit per symbol, 01 selects DQPSK with 2 bits per symbol, and 10 and 11 are reserved for the CCK rates and are sent as DQPSK.
- R6: Phase is an index p in 0..3, in steps of 90 degrees. A DBPSK symbol adds 2 when its scrambled bit is 1 and adds 0 when it is 0. A DQPSK symbol takes its scrambled bits in order (first, second) and adds 0 for 00, 1 for 01, 2 for 11 and 3 for 10. The symbol signs are: p=0 gives (I+,Q+), 1 gives (I-,Q+), 2 gives (I-,Q-), 3 gives (I+,Q-).
- R7: The phase index is 0 before the first preamble symbol. It is never reset at the preamble-to-header or header-to-payload boundaries.
- R8: Every bit passes through a scrambler with polynomial 1 + z^-4 + z^-7: out = in XOR s[3] XOR s[6], then s = {s[5:0], out}. s[0] is the most recent output. `start` loads s from `seed`, and the state carries through all sections.
- R9: Each symbol lasts 11 clocks, with one chip per clock, and `chip_valid` stays high without gaps from the first chip to the last. Chip k (k = 0..10) is multiplied by the Barker chip k from the sequence +1,-1,+1,+1,-1,+1,+1,+1,-1,-1,-1. An output bit of 1 means negative.
- R10: `bit_req` is high for one clock per host bit, and `bit_in` is sampled at the rising edge that ends that clock. A symbol's bits are requested in chips 0 and 1 of the symbol before it, first bit first.
- R11: `done` is high for exactly one clock, the clock after the last chip, and the block is then idle with `chip_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Packet launch pulse, honoured only when idle |
| hdr_mode | input | 1 | Header modulation: 0 DBPSK, 1 DQPSK |
| data_mode | input | 2 | Payload modulation code |
| pre_len | input | LEN_W | Preamble length in symbols |
| hdr_len | input | LEN_W | Header length in symbols |
| dat_len | input | LEN_W | Payload length in symbols |
| seed | input | 7 | Scrambler initial state |
| bit_req | output | 1 | Host bit request |
| bit_in | input | 1 | Host bit, valid while bit_req is high |
| chip_valid | output | 1 | A chip is present on the sign outputs |
| chip_i_neg | output | 1 | I chip sign, 1 means negative |
| chip_q_neg | output | 1 | Q chip sign, 1 means negative |
| done | output | 1 | One-clock end-of-packet pulse |

## Verification
A fault in the scrambler state or the phase accumulator corrupts the sign pattern at once, in the first chip of the next symbol, and the error never recovers because both are recursive. A fault in the section or symbol counters shows up as the wrong number of `bit_req` pulses, or as a mode change at the wrong symbol. The same fault also moves the `done` pulse away from chip count 11 times the total symbol count. The bench compares every chip of every packet across all header and payload modes, two seeds, and both single-symbol and multi-symbol sections, so any such fault appears within one symbol of where it starts.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

    parameter int CHIPS = 11;
    parameter int SCR_W = 7;

    // bit k set when Barker chip k is -1
    localparam logic [CHIPS-1:0] BARKER_NEG = 11'b111_0001_0010;

    typedef enum logic [1:0] {
        SEC_PRE = 2'd0,
        SEC_HDR = 2'd1,
        SEC_DAT = 2'd2,
        SEC_END = 2'd3
    } sec_e;

    typedef struct packed {
        logic hdr_dq;
        logic dat_dq;
    } mode_t;

    typedef struct packed {
        logic i_neg;
        logic q_neg;
    } iq_t;

    function automatic sec_e sec_after(input sec_e s);
        case (s)
            SEC_PRE: return SEC_HDR;
            SEC_HDR: return SEC_DAT;
            default: return SEC_END;
        endcase
    endfunction

    function automatic logic [1:0] phase_step(input logic dq, input logic s0, input logic s1);
        if (!dq) return s0 ? 2'd2 : 2'd0;
        case ({s0, s1})
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    function automatic iq_t phase_signs(input logic [1:0] p);
        iq_t r;
        r.i_neg = p[0] ^ p[1];
        r.q_neg = p[1];
        return r;
    endfunction

endpackage

// File: rtl/dsss_scrambler.sv
module dsss_scrambler
    import dsss_pkg::*;
#(
    parameter int W     = SCR_W,
    parameter int TAP_A = 4,
    parameter int TAP_B = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         init,
    input  logic         step,
    input  logic [W-1:0] seed,
    input  logic         dq,
    input  logic         d0,
    input  logic         d1,
    output logic         s0,
    output logic         s1
);

    logic [W-1:0] sr;
    logic [W-1:0] base;
    logic [W-1:0] mid;
    logic [W-1:0] nxt;

    always_comb begin
        base = init ? seed : sr;
        s0   = d0 ^ base[TAP_A-1] ^ base[TAP_B-1];
        mid  = {base[W-2:0], s0};
        s1   = d1 ^ mid[TAP_A-1] ^ mid[TAP_B-1];
        nxt  = dq ? {mid[W-2:0], s1} : mid;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (init || step) begin
            sr <= nxt;
        end
    end

    // R8: the state only moves when a symbol is loaded
    a_r8_state_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(init) && !$past(step) && !$past(rst)) |-> $stable(sr));

endmodule

// File: rtl/dsss_diff_enc.sv
module dsss_diff_enc
    import dsss_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       init,
    input  logic       step,
    input  logic       dq,
    input  logic       s0,
    input  logic       s1,
    output logic [1:0] phase
);

    logic [1:0] inc;

    always_comb inc = phase_step(dq, s0, s1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= 2'd0;
        end else if (init) begin
            phase <= inc;
        end else if (step) begin
            phase <= phase + inc;
        end
    end

    // R6: a DBPSK symbol can only keep or invert the phase
    a_r6_dbpsk_half: assert property (@(posedge clk) disable iff (rst)
        (step && !dq && !init) |=> (phase[0] == $past(phase[0])));

endmodule

// File: rtl/dsss_spreader.sv
module dsss_spreader
    import dsss_pkg::*;
#(
    parameter int CNT_W = $clog2(CHIPS)
) (
    input  logic             valid,
    input  logic [1:0]       phase,
    input  logic [CNT_W-1:0] chip_idx,
    output iq_t              chip
);

    iq_t sym;
    logic bneg;

    always_comb begin
        sym  = phase_signs(phase);
        bneg = BARKER_NEG[chip_idx];
        chip.i_neg = valid & (sym.i_neg ^ bneg);
        chip.q_neg = valid & (sym.q_neg ^ bneg);
    end

endmodule

// File: rtl/dsss_seq_ctrl.sv
module dsss_seq_ctrl
    import dsss_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = $clog2(CHIPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             hdr_mode,
    input  logic [1:0]       data_mode,
    input  logic [LEN_W-1:0] pre_len,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [LEN_W-1:0] dat_len,
    input  logic             bit_in,
    output logic             active,
    output logic             bit_req,
    output logic             ld_init,
    output logic             ld_step,
    output logic             ld_dq,
    output logic             d0,
    output logic             d1,
    output logic [CNT_W-1:0] chip_idx,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST_CHIP = CNT_W'(CHIPS - 1);

    sec_e             sec;
    logic [LEN_W-1:0] left;
    logic [CNT_W-1:0] chip_cnt;
    logic [1:0]       hbuf;
    mode_t            mode_q;
    logic [LEN_W-1:0] hdr_len_q;
    logic [LEN_W-1:0] dat_len_q;

    logic             last_in_sec;
    sec_e             nxt_sec;
    logic             nxt_dq;
    logic             nxt_host;
    logic             sym_end;
    logic [LEN_W-1:0] nxt_len;

    always_comb begin
        last_in_sec = (left == LEN_W'(1));
        nxt_sec     = last_in_sec ? sec_after(sec) : sec;
        case (nxt_sec)
            SEC_HDR: nxt_dq = mode_q.hdr_dq;
            SEC_DAT: nxt_dq = mode_q.dat_dq;
            default: nxt_dq = 1'b0;
        endcase
        nxt_len  = (nxt_sec == SEC_HDR) ? hdr_len_q : dat_len_q;
        nxt_host = (nxt_sec == SEC_HDR) || (nxt_sec == SEC_DAT);
        sym_end  = active && (chip_cnt == LAST_CHIP);
        bit_req  = active && nxt_host &&
                   ((chip_cnt == '0) || (chip_cnt == CNT_W'(1) && nxt_dq));
        ld_init  = !active && start;
        ld_step  = sym_end && (nxt_sec != SEC_END);
        ld_dq    = ld_init ? 1'b0 : nxt_dq;
        d0       = (ld_init || nxt_sec == SEC_PRE) ? 1'b1 : hbuf[0];
        d1       = hbuf[1];
        chip_idx = chip_cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            done      <= 1'b0;
            sec       <= SEC_PRE;
            left      <= '0;
            chip_cnt  <= '0;
            hbuf      <= '0;
            mode_q    <= '0;
            hdr_len_q <= '0;
            dat_len_q <= '0;
        end else begin
            done <= 1'b0;
            if (ld_init) begin
                active        <= 1'b1;
                sec           <= SEC_PRE;
                left          <= pre_len;
                chip_cnt      <= '0;
                mode_q.hdr_dq <= hdr_mode;
                mode_q.dat_dq <= (data_mode != 2'b00);
                hdr_len_q     <= hdr_len;
                dat_len_q     <= dat_len;
            end else if (active) begin
                if (bit_req) hbuf[chip_cnt[0]] <= bit_in;
                if (sym_end) begin
                    chip_cnt <= '0;
                    if (nxt_sec == SEC_END) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        sec  <= nxt_sec;
                        left <= last_in_sec ? nxt_len : left - LEN_W'(1);
                    end
                end else begin
                    chip_cnt <= chip_cnt + CNT_W'(1);
                end
            end
        end
    end

    // R10: requests only while a packet is running
    a_r10_req_active: assert property (@(posedge clk) disable iff (rst)
        bit_req |-> active);
    // R10: a single-bit symbol asks once
    a_r10_single_req: assert property (@(posedge clk) disable iff (rst)
        (bit_req && !nxt_dq) |=> !bit_req);
    // R11: done is a one-clock pulse seen only when idle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !active);
    // R9: chip index stays inside a symbol
    a_r9_chip_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (chip_cnt <= LAST_CHIP));
    // R2: a start while busy does not end the packet
    a_r2_busy_start: assert property (@(posedge clk) disable iff (rst)
        (active && start && !sym_end) |=> active);
    // R3: the preamble never asks the host for bits
    a_r3_pre_silent: assert property (@(posedge clk) disable iff (rst)
        (active && sec == SEC_PRE && !last_in_sec) |-> !bit_req);

endmodule

// File: rtl/dsss_tx_seq.sv
module dsss_tx_seq
    import dsss_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int SEED_W = SCR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              hdr_mode,
    input  logic [1:0]        data_mode,
    input  logic [LEN_W-1:0]  pre_len,
    input  logic [LEN_W-1:0]  hdr_len,
    input  logic [LEN_W-1:0]  dat_len,
    input  logic [SEED_W-1:0] seed,
    output logic              bit_req,
    input  logic              bit_in,
    output logic              chip_valid,
    output logic              chip_i_neg,
    output logic              chip_q_neg,
    output logic              done
);

    localparam int CNT_W = $clog2(CHIPS);

    logic             active;
    logic             ld_init;
    logic             ld_step;
    logic             ld_dq;
    logic             d0;
    logic             d1;
    logic             s0;
    logic             s1;
    logic [CNT_W-1:0] chip_idx;
    logic [1:0]       phase;
    iq_t              chip;

    dsss_seq_ctrl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .hdr_mode (hdr_mode),
        .data_mode(data_mode),
        .pre_len  (pre_len),
        .hdr_len  (hdr_len),
        .dat_len  (dat_len),
        .bit_in   (bit_in),
        .active   (active),
        .bit_req  (bit_req),
        .ld_init  (ld_init),
        .ld_step  (ld_step),
        .ld_dq    (ld_dq),
        .d0       (d0),
        .d1       (d1),
        .chip_idx (chip_idx),
        .done     (done)
    );

    dsss_scrambler #(.W(SEED_W)) u_scr (
        .clk (clk),
        .rst (rst),
        .init(ld_init),
        .step(ld_step),
        .seed(seed),
        .dq  (ld_dq),
        .d0  (d0),
        .d1  (d1),
        .s0  (s0),
        .s1  (s1)
    );

    dsss_diff_enc u_enc (
        .clk  (clk),
        .rst  (rst),
        .init (ld_init),
        .step (ld_step),
        .dq   (ld_dq),
        .s0   (s0),
        .s1   (s1),
        .phase(phase)
    );

    dsss_spreader #(.CNT_W(CNT_W)) u_spr (
        .valid   (active),
        .phase   (phase),
        .chip_idx(chip_idx),
        .chip    (chip)
    );

    always_comb begin
        chip_valid = active;
        chip_i_neg = chip.i_neg;
        chip_q_neg = chip.q_neg;
    end

    // R9: the chip stream has no gap inside a packet
    a_r9_no_gap: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_valid) |-> done);

endmodule

// File: tb/dsss_tx_seq_bench.sv
module dsss_tx_seq_bench;

    localparam int LEN_W = 8;
    localparam logic [10:0] BK = 11'b111_0001_0010;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       hdr_mode = 1'b0;
    logic [1:0] data_mode = 2'b00;
    logic [LEN_W-1:0] pre_len = '0, hdr_len = '0, dat_len = '0;
    logic [6:0] seed = '0;
    logic       bit_in = 1'b0;
    logic       bit_req, chip_valid, chip_i_neg, chip_q_neg, done;

    int errors = 0;
    int checks = 0;

    logic hb [0:63];
    logic exp_i [0:255];
    logic exp_q [0:255];
    int   n_chips, n_bits;

    always #5 clk = ~clk;

    dsss_tx_seq #(.LEN_W(LEN_W)) u_dsss_tx_seq (
        .clk(clk), .rst(rst), .start(start), .hdr_mode(hdr_mode),
        .data_mode(data_mode), .pre_len(pre_len), .hdr_len(hdr_len),
        .dat_len(dat_len), .seed(seed), .bit_req(bit_req), .bit_in(bit_in),
        .chip_valid(chip_valid), .chip_i_neg(chip_i_neg),
        .chip_q_neg(chip_q_neg), .done(done)
    );

    task automatic check(input bit ok, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    task automatic build_exp(input logic hm, input logic [1:0] dm,
                             input int pl, input int hl, input int dl,
                             input logic [6:0] sd);
        logic [6:0] sr;
        logic [1:0] ph;
        logic       dq, s0, s1;
        int b, c, n;
        sr = sd; ph = 2'd0; b = 0; c = 0;
        for (int sec = 0; sec < 3; sec++) begin
            n  = (sec == 0) ? pl : (sec == 1) ? hl : dl;
            dq = (sec == 0) ? 1'b0 : (sec == 1) ? hm : (dm != 2'b00);
            for (int s = 0; s < n; s++) begin
                s0 = ((sec == 0) ? 1'b1 : hb[b]) ^ sr[3] ^ sr[6];
                if (sec != 0) b++;
                sr = {sr[5:0], s0};
                if (dq) begin
                    s1 = hb[b] ^ sr[3] ^ sr[6];
                    b++;
                    sr = {sr[5:0], s1};
                    case ({s0, s1})
                        2'b00: ph = ph + 2'd0;
                        2'b01: ph = ph + 2'd1;
                        2'b11: ph = ph + 2'd2;
                        default: ph = ph + 2'd3;
                    endcase
                end else begin
                    ph = ph + (s0 ? 2'd2 : 2'd0);
                end
                for (int k = 0; k < 11; k++) begin
                    exp_i[c] = (ph == 2'd1 || ph == 2'd2) ^ BK[k];
                    exp_q[c] = (ph >= 2'd2) ^ BK[k];
                    c++;
                end
            end
        end
        n_chips = c;
        n_bits  = b;
    endtask

    task automatic run_pkt(input logic hm, input logic [1:0] dm,
                           input int pl, input int hl, input int dl,
                           input logic [6:0] sd, input int tag);
        int chip_n, bits_n, mism, cyc, late_req, done_at;
        bit done_seen;
        for (int k = 0; k < 64; k++) hb[k] = 1'(((k * 7 + tag * 13) ^ (k >> 2)) % 3 == 1);
        build_exp(hm, dm, pl, hl, dl, sd);
        hdr_mode = hm; data_mode = dm;
        pre_len = LEN_W'(pl); hdr_len = LEN_W'(hl); dat_len = LEN_W'(dl);
        seed = sd;
        chip_n = 0; bits_n = 0; mism = 0; cyc = 0; late_req = 0;
        done_seen = 0; done_at = -1;
        @(negedge clk);
        start = 1'b1;
        while (!done_seen && cyc < 3000) begin
            @(negedge clk);
            cyc++;
            start = (chip_n == 30);
            if (chip_n == 15) begin
                hdr_mode = ~hm; data_mode = ~dm;
                pre_len = 9; hdr_len = 7; dat_len = 1; seed = ~sd;
            end
            if (bit_req) begin
                if ((chip_n % 11) > 1) late_req++;
                bit_in = hb[bits_n];
                bits_n++;
            end
            if (chip_valid) begin
                if (chip_n < 256 && (chip_i_neg !== exp_i[chip_n] || chip_q_neg !== exp_q[chip_n])) begin
                    if (mism == 0)
                        $display("FAIL R2 R3 R4 R5 R6 R7 R8 R9 pkt %0d chip %0d: actual=%0d%0d expected=%0d%0d",
                                 tag, chip_n, chip_i_neg, chip_q_neg, exp_i[chip_n], exp_q[chip_n]);
                    mism++;
                end
                chip_n++;
            end
            if (done) begin
                done_seen = 1;
                done_at = chip_n;
            end
        end
        start = 1'b0;
        // chip stream: scrambling, phase rules, section modes, spreading, ignored cfg changes
        checks++;
        if (mism != 0) errors++;
        check(done_seen && done_at == n_chips, "R11 done after last chip", done_at, n_chips);
        check(bits_n == n_bits && late_req == 0, "R10 host bit requests", bits_n, n_bits);
        @(negedge clk);
        check(!done && !chip_valid, "R11 single pulse then idle", int'(done) + int'(chip_valid), 0);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!chip_valid && !bit_req && !done && !chip_i_neg && !chip_q_neg,
              "R1 reset outputs", int'(chip_valid) + int'(bit_req) + int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!chip_valid && !bit_req && !done, "R1 idle after reset", int'(chip_valid), 0);
        begin
            int tag = 0;
            for (int hm = 0; hm < 2; hm++)
                for (int dm = 0; dm < 4; dm++)
                    for (int ls = 0; ls < 2; ls++)
                        for (int sd = 0; sd < 2; sd++) begin
                            run_pkt(1'(hm), 2'(dm),
                                    ls ? 3 : 1, ls ? 2 : 1, ls ? 4 : 1,
                                    sd ? 7'h5B : 7'h00, tag);
                            tag++;
                        end
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule